// File: doc/BRIEF.md
# 4:2:2 Video Stream Demultiplexer and Remultiplexer

This block sits at the edge of a video processing core. On the input side it takes video on up to four 13-bit ports, laid out as full-rate 4:4:4:4, as 4:2:2:4 with separate chroma ports, as 4:2:2:4 with both chroma components sharing one port, or as 4:2:2:4 with luma and both chroma components on a single port. It rebuilds four parallel streams for the core: luma, blue-difference chroma, red-difference chroma and key. It also raises a core clock enable, which pulses every other cycle when the single-port layout runs the core at half rate.

The output side does the reverse. It takes the core's four streams and interleaves them onto four output ports in the same layout. Both sides share one phase counter. That counter is locked either by a registered high-to-low edge on the sync input or by holding the align input high, and it runs freely otherwise. Every input, including the control inputs, is registered on the rising clock edge. Data narrower than 13 bits is expected to be MSB-aligned on the ports.

Top module: `vid422_demux_mux`

## Requirements
- R1: While rst_n is low, all data outputs and core_en are 0.
- R2: With fmt = 0 (4:4:4:4), core_y, core_cb, core_cr and core_key take in_a, in_b, in_c and in_d two rising edges after presentation, and core_en is 1.
- R3: With fmt = 1 (4:2:2:4, separate chroma ports), core_y and core_key follow in_a and in_d every cycle, while core_cb and core_cr load in_b and in_c only for even-phase samples (phase 0 or 2) and hold otherwise; core_en is 1.
- R4: With fmt = 2 (chroma shared on in_b), an even-phase in_b sample goes to core_cb and an odd-phase one goes to core_cr; in_a feeds core_y and in_d feeds core_key every cycle; core_en is 1.
- R5: With fmt = 3 (single port), in_a samples at phases 0, 1, 2, 3 go to core_cb, core_y, core_cr, core_y. core_key loads in_d only with the luma samples. core_en is 1 only in the cycle after a luma sample is captured, so it is never high in two consecutive cycles.
- R6: A sample presented in the first cycle in which sync_in is low after a cycle in which it was high has phase 0.
- R7: A sample presented while align_in is high has phase 0. In fmt = 3 this makes core_en 0 in the result cycle.
- R8: With fmt = 0 or 1, out_w, out_x, out_y and out_z take mx_y, mx_cb, mx_cr and mx_key two rising edges after presentation.
- R9: With fmt = 2, out_x carries mx_cb for even-phase samples and mx_cr for odd-phase samples, out_y is 0, out_w carries mx_y and out_z carries mx_key.
- R10: With fmt = 3, out_w carries mx_cb, mx_y, mx_cr, mx_y for phases 0, 1, 2, 3. out_x and out_y are 0, and out_z carries mx_key.
- R11: Without a sync edge or align, the phase advances by one each cycle, modulo 4. Input and output samples presented in the same cycle share a phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt | input | 2 | Layout select: 0 full, 1 separate chroma, 2 shared chroma port, 3 single port |
| sync_in | input | 1 | Phase marker; a registered high-to-low edge marks a chroma sample |
| align_in | input | 1 | Level phase alignment for the half-rate core |
| in_a | input | 13 | Input port A (luma or interleaved stream) |
| in_b | input | 13 | Input port B (Cb or Cb/Cr) |
| in_c | input | 13 | Input port C (Cr) |
| in_d | input | 13 | Input port D (key) |
| core_en | output | 1 | Core clock enable |
| core_y | output | 13 | Rebuilt luma stream |
| core_cb | output | 13 | Rebuilt Cb stream |
| core_cr | output | 13 | Rebuilt Cr stream |
| core_key | output | 13 | Rebuilt key stream |
| mx_y | input | 13 | Core luma to the output multiplexer |
| mx_cb | input | 13 | Core Cb to the output multiplexer |
| mx_cr | input | 13 | Core Cr to the output multiplexer |
| mx_key | input | 13 | Core key to the output multiplexer |
| out_w | output | 13 | Output port W |
| out_x | output | 13 | Output port X |
| out_y | output | 13 | Output port Y |
| out_z | output | 13 | Output port Z |

## Verification
The hardest case to reach is a phase re-lock that lands in the middle of the single-port sequence. Here a sync edge or an align pulse arrives while the counter sits at phase 1 or 3, so the half-rate enable must give up its alternation and restart with no double pulse. The stimulus runs every layout with random data and drops in sync falls and align pulses at random cycles. Directed sequences then force a sync fall and an align pulse in the single-port layout, followed by four free-running samples, to confirm that the phase comes back around to the chroma slot.

// File: rtl/vid422_demux_mux.sv
module vid422_demux_mux #(
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic          sync_in,
  input  logic          align_in,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  input  logic [DW-1:0] in_d,
  output logic          core_en,
  output logic [DW-1:0] core_y,
  output logic [DW-1:0] core_cb,
  output logic [DW-1:0] core_cr,
  output logic [DW-1:0] core_key,
  input  logic [DW-1:0] mx_y,
  input  logic [DW-1:0] mx_cb,
  input  logic [DW-1:0] mx_cr,
  input  logic [DW-1:0] mx_key,
  output logic [DW-1:0] out_w,
  output logic [DW-1:0] out_x,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_z
);
  localparam logic [1:0] F_FULL   = 2'd0;
  localparam logic [1:0] F_SEP    = 2'd1;
  localparam logic [1:0] F_SHARED = 2'd2;
  localparam logic [1:0] F_SINGLE = 2'd3;

  logic [1:0]    fmt_q;
  logic          sync_q, sync_d, align_q;
  logic [DW-1:0] a_q, b_q, c_q, d_q;
  logic [DW-1:0] my_q, mcb_q, mcr_q, mk_q;
  logic [1:0]    ph_cnt;

  wire       sync_fall = sync_d & ~sync_q;
  wire [1:0] ph        = (align_q | sync_fall) ? 2'd0 : ph_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= F_FULL;
      sync_q  <= 1'b0;
      sync_d  <= 1'b0;
      align_q <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      d_q     <= '0;
      my_q    <= '0;
      mcb_q   <= '0;
      mcr_q   <= '0;
      mk_q    <= '0;
      ph_cnt  <= 2'd0;
    end else begin
      fmt_q   <= fmt;
      sync_q  <= sync_in;
      sync_d  <= sync_q;
      align_q <= align_in;
      a_q     <= in_a;
      b_q     <= in_b;
      c_q     <= in_c;
      d_q     <= in_d;
      my_q    <= mx_y;
      mcb_q   <= mx_cb;
      mcr_q   <= mx_cr;
      mk_q    <= mx_key;
      ph_cnt  <= ph + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en  <= 1'b0;
      core_y   <= '0;
      core_cb  <= '0;
      core_cr  <= '0;
      core_key <= '0;
    end else begin
      case (fmt_q)
        F_FULL: begin
          core_en  <= 1'b1;
          core_y   <= a_q;
          core_cb  <= b_q;
          core_cr  <= c_q;
          core_key <= d_q;
        end
        F_SEP: begin
          core_en  <= 1'b1;
          core_y   <= a_q;
          core_key <= d_q;
          if (!ph[0]) begin
            core_cb <= b_q;
            core_cr <= c_q;
          end
        end
        F_SHARED: begin
          core_en  <= 1'b1;
          core_y   <= a_q;
          core_key <= d_q;
          if (!ph[0]) core_cb <= b_q;
          else        core_cr <= b_q;
        end
        default: begin
          core_en <= ph[0];
          case (ph)
            2'd0:    core_cb <= a_q;
            2'd2:    core_cr <= a_q;
            default: begin
              core_y   <= a_q;
              core_key <= d_q;
            end
          endcase
        end
      endcase
    end
  end

  wire [DW-1:0] w_nx = (fmt_q != F_SINGLE) ? my_q :
                       (ph == 2'd0) ? mcb_q :
                       (ph == 2'd2) ? mcr_q : my_q;
  wire [DW-1:0] x_nx = (fmt_q == F_SINGLE) ? '0 :
                       (fmt_q == F_SHARED && ph[0]) ? mcr_q : mcb_q;
  wire [DW-1:0] y_nx = fmt_q[1] ? '0 : mcr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_w <= '0;
      out_x <= '0;
      out_y <= '0;
      out_z <= '0;
    end else begin
      out_w <= w_nx;
      out_x <= x_nx;
      out_y <= y_nx;
      out_z <= mk_q;
    end
  end

  p_full_rate_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q != F_SINGLE) |=> core_en);

  p_half_rate_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == F_SINGLE && $past(fmt_q) == F_SINGLE && core_en) |=> !core_en);

  p_align_en_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (align_q && fmt_q == F_SINGLE) |=> !core_en);

  p_shared_y_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == F_SHARED) |=> (out_y == '0));

  p_single_xy_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == F_SINGLE) |=> (out_x == '0 && out_y == '0));

  p_key_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_z == $past(mk_q)));

endmodule

// File: tb/vid422_demux_mux_tb.sv
module vid422_demux_mux_tb;
  localparam int DW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    fmt = 2'd0;
  logic          sync_in = 1'b0, align_in = 1'b0;
  logic [DW-1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic [DW-1:0] mx_y = '0, mx_cb = '0, mx_cr = '0, mx_key = '0;
  logic          core_en;
  logic [DW-1:0] core_y, core_cb, core_cr, core_key;
  logic [DW-1:0] out_w, out_x, out_y, out_z;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  vid422_demux_mux #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .sync_in(sync_in), .align_in(align_in),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .core_en(core_en), .core_y(core_y), .core_cb(core_cb), .core_cr(core_cr),
    .core_key(core_key),
    .mx_y(mx_y), .mx_cb(mx_cb), .mx_cr(mx_cr), .mx_key(mx_key),
    .out_w(out_w), .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: sampled inputs of the previous edge, phase as an integer
  int m_fmt, m_sync, m_syncd, m_align, m_cnt;
  int m_a, m_b, m_c, m_d, m_my, m_mcb, m_mcr, m_mk;
  int e_en, e_y, e_cb, e_cr, e_k, e_w, e_x, e_yo, e_z;
  string tag_d, tag_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fmt = 0; m_sync = 0; m_syncd = 0; m_align = 0; m_cnt = 0;
      m_a = 0; m_b = 0; m_c = 0; m_d = 0; m_my = 0; m_mcb = 0; m_mcr = 0; m_mk = 0;
      e_en = 0; e_y = 0; e_cb = 0; e_cr = 0; e_k = 0; e_w = 0; e_x = 0; e_yo = 0; e_z = 0;
      tag_d = "R1"; tag_m = "R1";
    end else begin
      int p;
      p = (m_align == 1 || (m_syncd == 1 && m_sync == 0)) ? 0 : m_cnt;
      if (m_fmt == 0) begin
        e_en = 1; e_y = m_a; e_cb = m_b; e_cr = m_c; e_k = m_d; tag_d = "R2";
      end else if (m_fmt == 1) begin
        e_en = 1; e_y = m_a; e_k = m_d; tag_d = "R3";
        if (p % 2 == 0) begin e_cb = m_b; e_cr = m_c; end
      end else if (m_fmt == 2) begin
        e_en = 1; e_y = m_a; e_k = m_d; tag_d = "R4";
        if (p % 2 == 0) e_cb = m_b; else e_cr = m_b;
      end else begin
        tag_d = "R5";
        e_en = p % 2;
        if (p == 0) e_cb = m_a;
        else if (p == 2) e_cr = m_a;
        else begin e_y = m_a; e_k = m_d; end
      end
      e_z = m_mk;
      if (m_fmt <= 1) begin
        tag_m = "R8"; e_w = m_my; e_x = m_mcb; e_yo = m_mcr;
      end else if (m_fmt == 2) begin
        tag_m = "R9"; e_w = m_my; e_x = (p % 2 == 1) ? m_mcr : m_mcb; e_yo = 0;
      end else begin
        tag_m = "R10"; e_x = 0; e_yo = 0;
        e_w = (p == 0) ? m_mcb : (p == 2) ? m_mcr : m_my;
      end
      m_cnt = (p + 1) % 4;
      m_syncd = m_sync;
      m_fmt = fmt; m_sync = sync_in; m_align = align_in;
      m_a = in_a; m_b = in_b; m_c = in_c; m_d = in_d;
      m_my = mx_y; m_mcb = mx_cb; m_mcr = mx_cr; m_mk = mx_key;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(tag_d, "core_en", core_en, e_en);
      chk(tag_d, "core_y", core_y, e_y);
      chk(tag_d, "core_cb", core_cb, e_cb);
      chk(tag_d, "core_cr", core_cr, e_cr);
      chk(tag_d, "core_key", core_key, e_k);
      chk(tag_m, "out_w", out_w, e_w);
      chk(tag_m, "out_x", out_x, e_x);
      chk(tag_m, "out_y", out_y, e_yo);
      chk(tag_m, "out_z", out_z, e_z);
    end
  end

  task automatic step(input logic [DW-1:0] a, input logic s, input logic al);
    in_a = a; sync_in = s; align_in = al;
    in_b = DW'($urandom); in_c = DW'($urandom); in_d = DW'($urandom);
    mx_y = DW'($urandom); mx_cb = DW'($urandom); mx_cr = DW'($urandom); mx_key = DW'($urandom);
    @(negedge clk);
  endtask

  task automatic run_random(input logic [1:0] f, input int n);
    fmt = f;
    for (int i = 0; i < n; i++) begin
      int r;
      r = $urandom_range(0, 19);
      step(DW'($urandom), (r == 0), (r == 1));
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "core_en", core_en, 0);
    chk("R1", "core_y", core_y, 0);
    chk("R1", "core_cb", core_cb, 0);
    chk("R1", "out_w", out_w, 0);
    chk("R1", "out_x", out_x, 0);
    chk("R1", "out_z", out_z, 0);
    rst_n = 1'b1;
    cmp_on = 1;

    run_random(2'd0, 200);
    run_random(2'd1, 200);
    run_random(2'd2, 200);
    run_random(2'd3, 300);
    run_random(2'd2, 100);
    run_random(2'd0, 50);

    // R6: sync fall in single-port layout, sample becomes Cb
    fmt = 2'd3;
    step(13'h010, 1'b0, 1'b0);
    step(13'h020, 1'b0, 1'b0);
    step(13'h030, 1'b1, 1'b0);
    step(13'h111, 1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R6", "core_cb after sync fall", core_cb, 13'h111);
    @(negedge clk);

    // R7: align pulse, sample becomes Cb and core_en low
    step(13'h0AB, 1'b0, 1'b1);
    @(posedge clk); #1;
    chk("R7", "core_cb after align", core_cb, 13'h0AB);
    chk("R7", "core_en after align", core_en, 0);
    @(negedge clk);

    // R11: free-running phases 1,2,3,0 after the align sample
    step(13'h0C1, 1'b0, 1'b0);
    step(13'h0C2, 1'b0, 1'b0);
    step(13'h0C3, 1'b0, 1'b0);
    step(13'h0C4, 1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R11", "core_cb wrap to phase 0", core_cb, 13'h0C4);
    chk("R11", "core_cr at phase 2", core_cr, 13'h0C2);
    chk("R11", "core_y at phase 3", core_y, 13'h0C3);
    @(negedge clk);

    run_random(2'd3, 200);
    run_random(2'd1, 100);
    step('0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0);
    cmp_on = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule